// File: doc/BRIEF.md
# Joystick Axis Timing Unit

This block turns up to four joystick axis pulses into numbers. Each axis is an analog one-shot in the real system; here each is a digital input that goes high after a measurement is started and falls back low after a time that depends on the stick position. A counter per axis counts prescaled ticks while its input is high, so the count taken at the fall is proportional to the axis position. The tick rate is chosen from four settings so that slow and fast pulse circuits both fit the 16-bit range.

Software drives the block through two byte registers and a 16-bit value port. A write strobe on the value port starts a measurement. When every enabled axis has finished, the counts are copied into result latches, a ready flag rises and, if allowed, a one-cycle interrupt pulse is issued. A select field picks which latched result the value port shows. In continuous mode the unit restarts itself after every completion, refreshing the latches and pulsing the interrupt each time. A write strobe on the compatibility port also raises an interrupt pulse when at least one axis is enabled and interrupts are allowed.

Top module: `gp_axis_unit`

## Requirements
- R1: After reset the configuration read-back, the hardware-setup read-back, the value port and the interrupt output are all zero.
- R2: Configuration register layout: bits 3:0 enable axes 0 to 3, bits 5:4 select the axis shown on the value port (0 to 3), bit 6 selects continuous mode, bit 7 is the ready flag; a write to bit 7 is ignored.
- R3: Hardware-setup register layout: bit 0 allows the interrupt, bits 2:1 hold the rate code, bit 3 is a plain stored bit; bits 7:4 always read zero.
- R4: A strobe on `trig_wr` clears all axis counters and clears the ready flag at the next clock edge.
- R5: After a start, an enabled axis counts one per tick for each clock edge at which its input is high, and stops for good at the first edge at which its input is low; with divisor D and H high edges the result is floor(H/D).
- R6: Rate code (bits 2:1) 00 gives divisor 1, 10 gives 2, 01 gives 20, 11 gives 200.
- R7: A counter stops at 0xFFFF and never wraps; a saturated axis counts as finished even while its input stays high.
- R8: The ready flag rises once every enabled axis has finished; the result of a disabled axis reads 0 after a measurement.
- R9: Each completion produces exactly one one-cycle `irq` pulse when bit 0 of the hardware-setup register is 1, and none when it is 0.
- R10: With continuous mode off, once ready is set the latched results and `irq` do not change while the axis inputs move, until the next start.
- R11: With continuous mode on, the unit restarts itself after each completion, refreshing the latches and pulsing `irq` at every completion.
- R12: A strobe on `legacy_wr` pulses `irq` for one cycle when at least one axis is enabled and the interrupt is allowed, and has no effect on `irq` otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back including the ready flag |
| hw_wr | input | 1 | Write strobe for the hardware-setup register |
| hw_wdata | input | 8 | Hardware-setup write data |
| hw_rdata | output | 8 | Hardware-setup read-back |
| trig_wr | input | 1 | Value-port write strobe that starts a measurement |
| val_rdata | output | CNT_W | Latched result of the selected axis |
| legacy_wr | input | 1 | Compatibility-port write strobe |
| axis_in | input | 4 | Axis pulse inputs, high while an axis is being timed |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the unit with its default parameters: a 16-bit counter and divisors of 2, 20 and 200 for the slower rate codes. With these values a held-high axis saturates after about 65 thousand cycles, so the clamp at 0xFFFF and the finish-on-saturation rule are reached in a short run, and a 650-cycle pulse at the slowest rate shows the floor rounding of the tick divider. All four rate codes, mixed enable masks, continuous restarts and the frozen latches are driven through the register ports alone.

// File: rtl/gp_axis_pkg.sv
// Package: shared constants and types of the joystick axis timing unit.
// Assumes a fixed register layout for four axes.
package gp_axis_pkg;

    localparam int NUM_AXES = 4;
    localparam int SEL_W    = $clog2(NUM_AXES);

    // Rate code held in bits 2:1 of the hardware-setup register
    typedef enum logic [1:0] {
        RATE_FULL      = 2'b00,
        RATE_TWENTIETH = 2'b01,
        RATE_HALF      = 2'b10,
        RATE_SLOWEST   = 2'b11
    } rate_e;

    // Writable part of the configuration register (bit 7 is status)
    typedef struct packed {
        logic                cont;
        logic [SEL_W-1:0]    sel;
        logic [NUM_AXES-1:0] en;
    } cfg_t;

endpackage

// File: rtl/gp_tick_gen.sv
// Module: gp_tick_gen
// Produces a one-cycle tick every N running cycles, where N is picked by
// the rate code. Assumes clear restarts the phase so that the first tick
// falls on the N-th running edge after clear.
module gp_tick_gen
    import gp_axis_pkg::*;
#(
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOWEST   = 200
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  run,
    input  rate_e rate,
    output logic  tick
);
    localparam int PW = $clog2(DIV_SLOWEST + 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] limit;

    // Last phase value before a tick for the selected rate
    always_comb begin
        unique case (rate)
            RATE_FULL:      limit = '0;
            RATE_HALF:      limit = PW'(DIV_HALF - 1);
            RATE_TWENTIETH: limit = PW'(DIV_TWENTIETH - 1);
            default:        limit = PW'(DIV_SLOWEST - 1);
        endcase
    end

    assign tick = run && (phase >= limit);

    // Phase counter, wraps after each tick
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/gp_axis_counter.sv
// Module: gp_axis_counter
// Times one axis pulse: counts ticks while the input is high, stops for
// good at the first low sample, clamps at all-ones. Assumes the input is
// already synchronous to clk.
module gp_axis_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic             enable,
    input  logic             pulse_in,
    output logic [CNT_W-1:0] count,
    output logic             finished
);
    logic fell;
    logic sat;

    assign sat      = &count;
    assign finished = !enable || fell || sat;

    // Count while high, remember the first low sample
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            fell  <= 1'b0;
        end else if (run && enable && !fell) begin
            if (!pulse_in) begin
                fell <= 1'b1;
            end else if (tick && !sat) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gp_axis_unit.sv
// Module: gp_axis_unit (top)
// Joystick axis timing unit: register file, measurement sequencing,
// result latches and interrupt pulse. Assumes single-cycle write strobes
// and axis inputs synchronous to clk.
module gp_axis_unit
    import gp_axis_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOWEST   = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             hw_wr,
    input  logic [7:0]       hw_wdata,
    output logic [7:0]       hw_rdata,
    input  logic             trig_wr,
    output logic [CNT_W-1:0] val_rdata,
    input  logic             legacy_wr,
    input  logic [3:0]       axis_in,
    output logic             irq
);
    cfg_t       cfg_q;
    logic       ready_q;
    logic       irq_en_q;
    rate_e      rate_q;
    logic       spare_q;
    logic       measuring_q;
    logic       irq_q;

    logic [CNT_W-1:0] cnt   [NUM_AXES];
    logic [CNT_W-1:0] latch [NUM_AXES];
    logic [NUM_AXES-1:0] fin;

    logic tick;
    logic complete;
    logic publish;
    logic restart;

    // A run ends when every enabled axis is done; a start write wins
    assign complete = measuring_q && (&fin) && !trig_wr;
    // Results are published unless a one-shot run already reported
    assign publish  = complete && (cfg_q.cont || !ready_q);
    assign restart  = trig_wr || (complete && cfg_q.cont);

    gp_tick_gen #(
        .DIV_HALF      (DIV_HALF),
        .DIV_TWENTIETH (DIV_TWENTIETH),
        .DIV_SLOWEST   (DIV_SLOWEST)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .run   (measuring_q),
        .rate  (rate_q),
        .tick  (tick)
    );

    for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
        gp_axis_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (restart),
            .run      (measuring_q),
            .tick     (tick),
            .enable   (cfg_q.en[i]),
            .pulse_in (axis_in[i]),
            .count    (cnt[i]),
            .finished (fin[i])
        );

        // Result latch of one axis, loaded when a run is published
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch[i] <= '0;
            end else if (publish) begin
                latch[i] <= cnt[i];
            end
        end
    end

    // Configuration register; bit 7 of the write data is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_t'(cfg_wdata[6:0]);
        end
    end

    // Hardware-setup register: interrupt allow, rate code, spare bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            rate_q   <= RATE_FULL;
            spare_q  <= 1'b0;
        end else if (hw_wr) begin
            irq_en_q <= hw_wdata[0];
            rate_q   <= rate_e'(hw_wdata[2:1]);
            spare_q  <= hw_wdata[3];
        end
    end

    // Measurement state and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            measuring_q <= 1'b0;
            ready_q     <= 1'b0;
        end else if (trig_wr) begin
            measuring_q <= 1'b1;
            ready_q     <= 1'b0;
        end else if (complete) begin
            measuring_q <= cfg_q.cont;
            ready_q     <= 1'b1;
        end
    end

    // Interrupt pulse on published completion or compatibility write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_en_q && (publish || (legacy_wr && (|cfg_q.en)));
        end
    end

    assign cfg_rdata = {ready_q, cfg_q};
    assign hw_rdata  = {4'h0, spare_q, rate_q, irq_en_q};
    assign val_rdata = latch[cfg_q.sel];
    assign irq       = irq_q;

endmodule

// File: rtl/gp_axis_unit_chk.sv
// Module: gp_axis_unit_chk
// Port-level properties of the axis timing unit, attached by bind.
module gp_axis_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [7:0]       cfg_rdata,
    input logic [7:0]       hw_rdata,
    input logic             trig_wr,
    input logic [CNT_W-1:0] val_rdata,
    input logic             irq
);
    // R3: upper nibble of the hardware-setup read-back stays zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rdata[7:4] == 4'h0);

    // R4: a start write clears ready at the next edge
    a_r4_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> !cfg_rdata[7]);

    // R9: no interrupt pulse unless the interrupt was allowed
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(hw_rdata[0]));

    // R8: a rising ready with interrupts allowed comes with a pulse
    a_r8_ready_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_rdata[7]) && $past(hw_rdata[0])) |-> irq);

    // R10: one-shot results stay put once ready
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] && !cfg_rdata[6] && !trig_wr && !cfg_wr) |=> $stable(val_rdata));

endmodule

bind gp_axis_unit gp_axis_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .hw_rdata  (hw_rdata),
    .trig_wr   (trig_wr),
    .val_rdata (val_rdata),
    .irq       (irq)
);

// File: tb/gp_axis_unit_tb.sv
module gp_axis_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    // {rate[1:0], en[3:0], len0, len1, len2, len3}
    localparam logic [69:0] VEC [NV] = '{
        {2'b00, 4'hF, 16'd5,  16'd17,  16'd0,   16'd40},
        {2'b10, 4'hF, 16'd9,  16'd10,  16'd3,   16'd1},
        {2'b01, 4'h5, 16'd45, 16'd100, 16'd200, 16'd7},
        {2'b11, 4'h8, 16'd0,  16'd0,   16'd0,   16'd650},
        {2'b00, 4'h0, 16'd30, 16'd30,  16'd30,  16'd30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, hw_wr = 1'b0, trig_wr = 1'b0, legacy_wr = 1'b0;
    logic [7:0] cfg_wdata = '0, hw_wdata = '0;
    logic [3:0] axis_in = '0;
    logic [7:0] cfg_rdata, hw_rdata;
    logic [15:0] val_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_axis_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .hw_wr(hw_wr), .hw_wdata(hw_wdata), .hw_rdata(hw_rdata),
        .trig_wr(trig_wr), .val_rdata(val_rdata),
        .legacy_wr(legacy_wr), .axis_in(axis_in), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wr_hw(input logic [7:0] d);
        @(negedge clk); hw_wr = 1'b1; hw_wdata = d;
        @(negedge clk); hw_wr = 1'b0;
    endtask

    function automatic int div_of(input logic [1:0] code);
        case (code)
            2'b00: return 1;
            2'b10: return 2;
            2'b01: return 20;
            default: return 200;
        endcase
    endfunction

    // Start a run, shape the axis pulses, wait for ready, count pulses
    task automatic run_meas(input logic [3:0] en, input logic [1:0] rate,
                            input int len[4], input bit ien,
                            output int irqs, output bit rdy);
        int e;
        wr_hw({5'b0, rate, ien});
        wr_cfg({4'b0, en});
        @(negedge clk); trig_wr = 1'b1; axis_in = '0;
        @(negedge clk); trig_wr = 1'b0;
        chk("R4 ready cleared by start", cfg_rdata[7], 0);
        irqs = 0; rdy = 0; e = 1;
        while (e < 80000 && !rdy) begin
            for (int i = 0; i < 4; i++) axis_in[i] = (e <= len[i]);
            @(negedge clk);
            if (irq) irqs++;
            rdy = cfg_rdata[7];
            e++;
        end
        axis_in = '0;
        repeat (5) begin
            @(negedge clk);
            if (irq) irqs++;
        end
    endtask

    task automatic read_axis(input logic [7:0] base, input int i, output int v);
        wr_cfg(base | 8'(i << 4));
        v = val_rdata;
    endtask

    initial begin
        int irqs, v, len[4], cnt;
        bit rdy;
        logic [69:0] row;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cfg reset", cfg_rdata, 0);
        chk("R1 hw reset", hw_rdata, 0);
        chk("R1 value reset", val_rdata, 0);
        chk("R1 irq reset", irq, 0);
        rst_n = 1'b1;
        // R2: ready bit is not writable
        wr_cfg(8'hFF);
        chk("R2 cfg readback", cfg_rdata, 8'h7F);
        wr_cfg(8'h00);
        // R3: upper bits read zero
        wr_hw(8'hFF);
        chk("R3 hw readback", hw_rdata, 8'h0F);

        // Vector table: R5, R6, R8, R9
        for (int n = 0; n < NV; n++) begin
            row = VEC[n];
            len[0] = row[63:48]; len[1] = row[47:32];
            len[2] = row[31:16]; len[3] = row[15:0];
            run_meas(row[67:64], row[69:68], len, 1'b1, irqs, rdy);
            chk("R8 ready after run", rdy, 1);
            chk("R9 one irq per run", irqs, 1);
            for (int i = 0; i < 4; i++) begin
                read_axis({4'b0, row[67:64]}, i, v);
                chk(row[64+i] ? "R5 R6 axis count" : "R8 disabled axis zero",
                    v, row[64+i] ? len[i] / div_of(row[69:68]) : 0);
            end
        end

        // R10: frozen results after a one-shot run
        len = '{5, 17, 0, 40};
        run_meas(4'hF, 2'b00, len, 1'b1, irqs, rdy);
        wr_cfg(8'h1F);
        axis_in = 4'hF;
        cnt = 0;
        repeat (30) begin @(negedge clk); if (irq) cnt++; end
        axis_in = '0;
        chk("R10 latch frozen", val_rdata, 17);
        chk("R10 no irq while frozen", cnt, 0);
        chk("R10 ready kept", cfg_rdata[7], 1);

        // R9: interrupt disallowed
        len = '{3, 3, 3, 3};
        run_meas(4'h1, 2'b00, len, 1'b0, irqs, rdy);
        chk("R9 no irq when disallowed", irqs, 0);
        chk("R9 run still completes", rdy, 1);

        // R7: saturation with input still high
        len = '{0, 100000, 0, 0};
        run_meas(4'h2, 2'b00, len, 1'b1, irqs, rdy);
        chk("R7 saturated axis finishes", rdy, 1);
        read_axis(8'h02, 1, v);
        chk("R7 clamp at 0xFFFF", v, 16'hFFFF);

        // R11: continuous mode refreshes and re-pulses
        len = '{12, 0, 0, 0};
        run_meas(4'h1, 2'b00, len, 1'b1, irqs, rdy);
        read_axis(8'h01, 0, v);
        chk("R11 seed value", v, 12);
        wr_cfg(8'h41);
        @(negedge clk); trig_wr = 1'b1;
        @(negedge clk); trig_wr = 1'b0;
        cnt = 0;
        repeat (20) begin @(negedge clk); if (irq) cnt++; end
        chk("R11 repeated irq", cnt >= 5, 1);
        chk("R11 latch refreshed", val_rdata, 0);
        wr_cfg(8'h01);
        repeat (5) @(negedge clk);

        // R12: compatibility-port write
        wr_hw(8'h01);
        wr_cfg(8'h03);
        @(negedge clk); legacy_wr = 1'b1;
        @(negedge clk); legacy_wr = 1'b0;
        chk("R12 irq on legacy write", irq, 1);
        @(negedge clk);
        chk("R12 pulse one cycle", irq, 0);
        wr_cfg(8'h00);
        @(negedge clk); legacy_wr = 1'b1;
        @(negedge clk); legacy_wr = 1'b0;
        chk("R12 no irq without enables", irq, 0);
        wr_cfg(8'h03);
        wr_hw(8'h00);
        @(negedge clk); legacy_wr = 1'b1;
        @(negedge clk); legacy_wr = 1'b0;
        chk("R12 no irq when disallowed", irq, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule